// File: doc/BRIEF.md
# UART Receiver with Break Detection

This block receives asynchronous serial characters from one input line. The line is resynchronised and watched for a falling edge. The start bit is confirmed at a programmable delay after that edge, and each following bit is sampled once per programmable bit period. A character holds 8 or 9 data bits, sent least significant bit first, and then an optional parity bit and one stop bit. In 9-bit mode the last data bit is reported on its own output, so it can serve as an address or mark flag.

Each received character is placed in an output register together with its parity and framing flags. It is offered on a ready/valid handshake and held there until it is taken. When a character arrives while the register is still full, the new character is dropped and a sticky overrun flag is raised.

Characters that fail framing and whose data bits are all zero are counted while they arrive back to back. When the count reaches a programmable limit, a break request is raised, which the surrounding system can use as a reset. The receiver rearms only after the line has been seen high once the stop bit has passed. A line that is held low therefore produces one character, not a stream of them.

Top module: `uart_rx_brk`

## Requirements
- R1: While reset is low, and on the cycle after it is released, out_valid, overrun and break_req are all 0.
- R2: With nine_bit=0, a frame carries 8 data bits, least significant first. They appear on out_data and out_bit9 is 0.
- R3: With nine_bit=1, a frame carries 9 data bits. The first 8 appear on out_data and the ninth appears on out_bit9.
- R4: With parity_en=1, one parity bit follows the data bits. Even parity is used when parity_odd=0 and odd parity when parity_odd=1. The XOR of all data bits and the parity bit must equal parity_odd, and out_par_err is 1 when it does not. With parity_en=0, out_par_err is 0.
- R5: A stop bit sampled low sets out_frm_err for that character. A stop bit sampled high clears it.
- R6: The start bit is sampled first_offset+1 cycles after the falling edge is detected. Each later bit is sampled bit_period cycles after the previous sample. A low pulse that has ended before the start sample produces no character, even when the pulse is longer than half a bit.
- R7: A start bit that reads high at its sample point returns the receiver to idle with no output.
- R8: After the stop bit has been sampled, no new start is detected until the line has been high. A line held low after a framing error yields exactly one character.
- R9: While out_valid=1 and out_ready=0, the output word and its flags stay unchanged. A character completed in that state is dropped and sets overrun. Overrun and out_valid clear on the cycle after out_valid and out_ready are both 1.
- R10: A null character has a framing error and all data bits zero, including the ninth bit in 9-bit mode. Each null character increments a counter. break_req is 1 while break_limit is nonzero and the counter is at or above break_limit.
- R11: Any character that is not null clears the counter and so drops break_req. This includes error-free characters and characters with any other error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| bit_period | input | DIV_W | Cycles per bit |
| first_offset | input | DIV_W | Cycles from detected start edge to start-bit sample, minus one |
| nine_bit | input | 1 | 1 selects 9 data bits |
| parity_en | input | 1 | 1 adds a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| break_limit | input | BRK_W | Null-character count that raises break_req; 0 disables it |
| out_ready | input | 1 | Consumer takes the held character |
| out_valid | output | 1 | A character is held |
| out_data | output | 8 | Data bits 0 to 7 |
| out_bit9 | output | 1 | Ninth data bit (address/mark flag) |
| out_par_err | output | 1 | Parity mismatch for the held character |
| out_frm_err | output | 1 | Stop bit was low for the held character |
| overrun | output | 1 | Sticky: a character was dropped while the output was full |
| break_req | output | 1 | Break/reset request |

## Verification
The bench sends a glitch shorter than the start delay. A receiver that trusts the edge alone would turn it into a spurious 0xFF character. It also sends a pulse longer than half a bit but shorter than a large programmed offset, which exposes a receiver that samples at a fixed half bit. After a framing error the line is held low. A receiver that rearms too early would produce a second null character and set overrun. The break tests interleave null characters with a good character and with a non-null framing error. A counter that fails to clear, or that counts the wrong frames, would raise break_req one frame early or never lower it. Parity is checked in both senses and in 9-bit mode, so an error that leaves out the ninth bit or inverts the sense is caught.

// File: rtl/uart_rx_brk.sv
module uart_rx_brk #(
  parameter int DIV_W = 16,
  parameter int BRK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] bit_period,
  input  logic [DIV_W-1:0] first_offset,
  input  logic             nine_bit,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic [BRK_W-1:0] break_limit,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_bit9,
  output logic             out_par_err,
  output logic             out_frm_err,
  output logic             overrun,
  output logic             break_req
);

  typedef enum logic [2:0] {S_WAIT, S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t              st;
  logic             sy1, rxs;
  logic [DIV_W-1:0] cnt;
  logic [3:0]       idx;
  logic [8:0]       sh;
  logic             pbit;
  logic [BRK_W-1:0] brk_cnt;

  wire       tick   = (cnt == '0);
  wire [3:0] last   = nine_bit ? 4'd8 : 4'd7;
  wire       done   = (st == S_STOP) && tick;
  wire [8:0] word   = nine_bit ? sh : {1'b0, sh[8:1]};
  wire       perr   = parity_en && ((^word) ^ pbit ^ parity_odd);
  wire       ferr   = !rxs;
  wire       nul    = ferr && (word == 9'd0);
  wire       take   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= 1'b1;
      rxs <= 1'b1;
    end else begin
      sy1 <= rx_i;
      rxs <= sy1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_WAIT;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else begin
      case (st)
        S_WAIT: if (rxs) st <= S_IDLE;
        S_IDLE:
          if (!rxs) begin
            st  <= S_START;
            cnt <= first_offset;
          end
        S_START:
          if (!tick) cnt <= cnt - 1'b1;
          else if (!rxs) begin
            st  <= S_DATA;
            cnt <= bit_period - 1'b1;
            idx <= '0;
          end else st <= S_IDLE;
        S_DATA:
          if (!tick) cnt <= cnt - 1'b1;
          else begin
            sh  <= {rxs, sh[8:1]};
            cnt <= bit_period - 1'b1;
            idx <= idx + 1'b1;
            if (idx == last) st <= parity_en ? S_PAR : S_STOP;
          end
        S_PAR:
          if (!tick) cnt <= cnt - 1'b1;
          else begin
            pbit <= rxs;
            cnt  <= bit_period - 1'b1;
            st   <= S_STOP;
          end
        S_STOP:
          if (!tick) cnt <= cnt - 1'b1;
          else st <= S_WAIT;
        default: st <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_bit9    <= 1'b0;
      out_par_err <= 1'b0;
      out_frm_err <= 1'b0;
      overrun     <= 1'b0;
    end else if (done && out_valid && !out_ready) begin
      overrun <= 1'b1;
    end else if (done) begin
      out_valid   <= 1'b1;
      out_data    <= word[7:0];
      out_bit9    <= word[8];
      out_par_err <= perr;
      out_frm_err <= ferr;
      overrun     <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) brk_cnt <= '0;
    else if (done) begin
      if (!nul) brk_cnt <= '0;
      else if (brk_cnt != '1) brk_cnt <= brk_cnt + 1'b1;
    end
  end

  assign break_req = (break_limit != '0) && (brk_cnt >= break_limit);

endmodule

module uart_rx_brk_chk #(
  parameter int BRK_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_bit9,
  input logic             out_par_err,
  input logic             out_frm_err,
  input logic             overrun,
  input logic             break_req,
  input logic [BRK_W-1:0] break_limit
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !overrun && !break_req));

  assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_bit9)
                                   && $stable(out_par_err) && $stable(out_frm_err)));

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(out_valid) && !$past(out_ready)));

  assert_break_on_null_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(break_req) && !$past(out_valid) && $stable(break_limit))
      |-> (out_valid && out_frm_err && out_data == 8'd0 && !out_bit9));

  assert_break_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(break_req) && !$past(out_valid) && $stable(break_limit))
      |-> (out_valid && (!out_frm_err || out_data != 8'd0 || out_bit9)));

endmodule

bind uart_rx_brk uart_rx_brk_chk #(.BRK_W(BRK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_bit9(out_bit9), .out_par_err(out_par_err),
  .out_frm_err(out_frm_err), .overrun(overrun), .break_req(break_req),
  .break_limit(break_limit)
);

// File: tb/tb_uart_rx_brk.sv
module tb_uart_rx_brk;
  localparam int DIV_W = 16;
  localparam int BRK_W = 8;
  localparam int BP    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_i = 1'b1;
  logic [DIV_W-1:0] bit_period = DIV_W'(BP);
  logic [DIV_W-1:0] first_offset = 16'd4;
  logic             nine_bit = 1'b0, parity_en = 1'b0, parity_odd = 1'b0;
  logic [BRK_W-1:0] break_limit = 8'd3;
  logic             out_ready = 1'b0;
  logic             out_valid, out_bit9, out_par_err, out_frm_err, overrun, break_req;
  logic [7:0]       out_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_rx_brk #(.DIV_W(DIV_W), .BRK_W(BRK_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .bit_period(bit_period),
    .first_offset(first_offset), .nine_bit(nine_bit), .parity_en(parity_en),
    .parity_odd(parity_odd), .break_limit(break_limit), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_bit9(out_bit9),
    .out_par_err(out_par_err), .out_frm_err(out_frm_err), .overrun(overrun),
    .break_req(break_req)
  );

  // {nine, pen, podd, flip, stop, data[8:0], exp_perr, exp_ferr}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0A5, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 9'h03C, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 9'h0FF, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 9'h081, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 9'h1A5, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'h155, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h012, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 9'h100, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    rx_i = v;
    repeat (BP) @(negedge clk);
  endtask

  task automatic send(input logic nine, input logic pen, input logic podd, input logic flip,
                      input logic stop, input logic [8:0] d, input int tail_low);
    logic p;
    int n;
    nine_bit = nine; parity_en = pen; parity_odd = podd;
    n = nine ? 9 : 8;
    p = podd;
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      p ^= d[i];
      hold_bit(d[i]);
    end
    if (pen) hold_bit(p ^ flip);
    hold_bit(stop);
    if (!stop) repeat (tail_low) @(negedge clk);
    rx_i = 1'b1;
    repeat (2 * BP) @(negedge clk);
  endtask

  task automatic accept();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_low(input int n);
    @(negedge clk);
    rx_i = 1'b0;
    repeat (n) @(negedge clk);
    rx_i = 1'b1;
    repeat (12 * BP) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 valid in reset", out_valid, 0);
    check("R1 overrun in reset", overrun, 0);
    check("R1 break in reset", break_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", out_valid, 0);
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5 table walk
    for (int k = 0; k < 8; k++) begin
      logic [15:0] v;
      v = VEC[k];
      send(v[15], v[14], v[13], v[12], v[11], v[10:2], 0);
      check("R2 valid", out_valid, 1);
      check("R2 data", out_data, v[9:2]);
      check("R3 bit9", out_bit9, v[15] ? v[10] : 1'b0);
      check("R4 parity err", out_par_err, v[1]);
      check("R5 framing err", out_frm_err, v[0]);
      accept();
      check("R9 released", out_valid, 0);
    end

    // R7 glitch shorter than start sample
    nine_bit = 0; parity_en = 0;
    pulse_low(2);
    check("R7 glitch ignored", out_valid, 0);

    // R6 long pulse with large offset is rejected, with small offset starts a frame
    first_offset = 16'd20;
    pulse_low(12);
    check("R6 large offset rejects pulse", out_valid, 0);
    first_offset = 16'd4;
    pulse_low(12);
    check("R6 small offset samples pulse", out_valid, 1);
    check("R6 idle bits read ones", out_data, 8'hFF);
    accept();

    // R8 line held low after a null frame
    send(0, 0, 0, 0, 0, 9'h000, 6 * BP);
    check("R8 one frame", out_valid, 1);
    check("R8 frame is framing err", out_frm_err, 1);
    check("R8 no second frame", overrun, 0);
    accept();
    repeat (12 * BP) @(negedge clk);
    check("R8 still idle", out_valid, 0);

    // R9 overrun
    send(0, 0, 0, 0, 1, 9'h011, 0);
    send(0, 0, 0, 0, 1, 9'h022, 0);
    check("R9 first kept", out_data, 8'h11);
    check("R9 overrun set", overrun, 1);
    accept();
    check("R9 valid cleared", out_valid, 0);
    check("R9 overrun cleared", overrun, 0);

    // R10 break after three nulls
    for (int k = 0; k < 3; k++) begin
      send(0, 0, 0, 0, 0, 9'h000, 0);
      check("R10 break count", break_req, k == 2);
      accept();
    end
    // R11 good frame clears
    send(0, 0, 0, 0, 1, 9'h055, 0);
    check("R11 good clears break", break_req, 0);
    accept();
    // R11 non-null error clears a partial count
    for (int k = 0; k < 2; k++) begin send(0, 0, 0, 0, 0, 9'h000, 0); accept(); end
    send(0, 0, 0, 0, 0, 9'h040, 0);
    check("R11 non-null error frame", out_frm_err, 1);
    accept();
    for (int k = 0; k < 2; k++) begin send(0, 0, 0, 0, 0, 9'h000, 0); accept(); end
    check("R11 count restarted", break_req, 0);
    send(0, 0, 0, 0, 0, 9'h000, 0);
    check("R10 break after limit", break_req, 1);
    accept();
    // R10 ninth bit set makes a frame non-null
    send(1, 0, 0, 0, 0, 9'h100, 0);
    check("R10 bit9 not null", break_req, 0);
    accept();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule